// File: doc/BRIEF.md
# Clock Correction Sequence Matcher

This block watches a stream of decoded receive symbols and reports when either of two programmed clock correction sequences has just been received. Each symbol is ten bits wide: an eight-bit data byte plus a flag that marks a control character and a flag that marks inverted disparity. All ten bits take part in the comparison. A sequence can be one, two or four symbols long, and each position can be turned into a don't-care by its enable bit.

The input is a valid/ready stream. The matcher only observes the stream and never applies back-pressure, so `in_ready` is always high. A symbol is accepted on every rising clock edge where `in_valid` is high. Cycles with `in_valid` low leave the history untouched. A hit is reported as a one-cycle pulse in the cycle after the symbol that completes the sequence. Sequence 1 has priority when both sequences complete on the same symbol.

Top module: `ccm_matcher`

## Requirements
- R1: Each received symbol is compared as the 10-bit value {in_disp, in_ctrl, in_data}. In a programmed symbol, bits 7:0 are the data byte, bit 8 is the control flag and bit 9 is the disparity flag. A difference in any of the ten bits at an enabled position prevents a match.
- R2: Position k (k = 1..4) of a sequence is held in bits [10k-1:10(k-1)] of its `seqN_sym` port. Position 1 is the earliest symbol and the highest used position is the most recently accepted symbol.
- R3: `seq_len` selects how many positions take part, for both sequences:
  - 2'b00 means one position.
  - 2'b01 means two positions.
  - 2'b10 and 2'b11 mean four positions.
  - Positions beyond the selected length are ignored.
- R4: Bit k-1 of `seqN_en` enables position k. When that bit is low, the position counts as matched whatever symbol was received.
- R5: `hit1` and `hit2` pulse high for exactly one cycle, in the cycle after the accepted symbol that completes the match. They are low in any cycle that does not follow an accepted symbol. A cycle with `in_valid` low does not shift the history, so a sequence split by idle cycles still matches.
- R6: `hit_any` is high when `hit1` or `hit2` is high. `hit_sel` is 0 when sequence 1 matched, including when both matched, and is 1 only when sequence 2 matched alone.
- R7: A synchronous active-high `rst` clears the history and all hit outputs. After reset, no hit is reported until at least as many symbols as the selected length have been accepted.
- R8: `in_ready` is always high; the block never stalls the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Symbol present on the stream |
| in_ready | output | 1 | Always high; no back-pressure |
| in_data | input | 8 | Received data byte |
| in_ctrl | input | 1 | Received symbol is a control character |
| in_disp | input | 1 | Received symbol has inverted disparity |
| seq_len | input | 2 | Length code for both sequences |
| seq1_sym | input | 40 | Sequence 1 symbols, position 1 in bits 9:0 |
| seq1_en | input | 4 | Sequence 1 per-position enables |
| seq2_sym | input | 40 | Sequence 2 symbols, position 1 in bits 9:0 |
| seq2_en | input | 4 | Sequence 2 per-position enables |
| hit1 | output | 1 | Sequence 1 just completed |
| hit2 | output | 1 | Sequence 2 just completed |
| hit_any | output | 1 | Either sequence just completed |
| hit_sel | output | 1 | 0 = sequence 1 reported, 1 = sequence 2 alone |

## Verification
The hardest situations to reach from the ports are the following:
- Both sequences complete on the same symbol.
- A four-symbol pattern is interleaved with idle cycles.
- A pattern whose only difference from the received symbol lies in the control or disparity flag.

Directed cases build each of these on purpose. They include a reversed-order feed that must not match and a mask-only sequence that exposes the fill rule right after reset. Random traffic then draws symbols from a four-symbol alphabet, with random idles and random masks and lengths, so that chance matches of every length occur often.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int DATA_W  = 8;
  localparam int SYM_W   = DATA_W + 2;
  localparam int MAX_POS = 4;
  localparam int NSEQ    = 2;
  localparam int CNT_W   = $clog2(MAX_POS + 1);

  typedef logic [SYM_W-1:0] sym_t;

  // length code: 00 -> 1, 01 -> 2, otherwise -> 4
  function automatic logic [CNT_W-1:0] len_decode(input logic [1:0] code);
    case (code)
      2'b00:   len_decode = CNT_W'(1);
      2'b01:   len_decode = CNT_W'(2);
      default: len_decode = CNT_W'(MAX_POS);
    endcase
  endfunction
endpackage

// File: rtl/ccm_history.sv
module ccm_history
  import ccm_pkg::*;
#(
  parameter int DEPTH = MAX_POS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  sym_t                   din,
  output logic [DEPTH*SYM_W-1:0] hist_nxt,
  output logic [CNT_W-1:0]       fill_nxt
);
  logic [DEPTH*SYM_W-1:0] hist_q;
  logic [CNT_W-1:0]       fill_q;

  // slot 0 (lowest slice) holds the newest symbol
  always_comb begin
    hist_nxt = hist_q;
    fill_nxt = fill_q;
    if (push) begin
      hist_nxt = {hist_q[(DEPTH-1)*SYM_W-1:0], din};
      if (fill_q < CNT_W'(DEPTH)) fill_nxt = fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/ccm_seq_cmp.sv
module ccm_seq_cmp
  import ccm_pkg::*;
#(
  parameter int DEPTH = MAX_POS
) (
  input  logic [DEPTH*SYM_W-1:0] hist,
  input  logic [DEPTH*SYM_W-1:0] pat,
  input  logic [DEPTH-1:0]       en,
  input  logic [CNT_W-1:0]       nlen,
  output logic                   match
);
  logic [DEPTH-1:0] pos_ok;

  for (genvar p = 0; p < DEPTH; p++) begin : g_pos
    sym_t cand;
    logic ok;
    // position p+1 lines up with history slot nlen-1-p
    always_comb begin
      cand = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j == int'(nlen) - 1 - p) cand = hist[j*SYM_W +: SYM_W];
      end
    end
    always_comb begin
      ok = 1'b1;
      if ((CNT_W'(p) < nlen) && en[p]) ok = (cand == pat[p*SYM_W +: SYM_W]);
    end
    assign pos_ok[p] = ok;
  end

  assign match = &pos_ok;
endmodule

// File: rtl/ccm_hit_merge.sv
module ccm_hit_merge (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic m1,
  input  logic m2,
  output logic hit1,
  output logic hit2,
  output logic hit_any,
  output logic hit_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit1    <= 1'b0;
      hit2    <= 1'b0;
      hit_any <= 1'b0;
      hit_sel <= 1'b0;
    end else begin
      hit1    <= fire & m1;
      hit2    <= fire & m2;
      hit_any <= fire & (m1 | m2);
      hit_sel <= fire & m2 & ~m1;
    end
  end
endmodule

// File: rtl/ccm_matcher.sv
module ccm_matcher
  import ccm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     in_ctrl,
  input  logic                     in_disp,
  input  logic [1:0]               seq_len,
  input  logic [MAX_POS*SYM_W-1:0] seq1_sym,
  input  logic [MAX_POS-1:0]       seq1_en,
  input  logic [MAX_POS*SYM_W-1:0] seq2_sym,
  input  logic [MAX_POS-1:0]       seq2_en,
  output logic                     hit1,
  output logic                     hit2,
  output logic                     hit_any,
  output logic                     hit_sel
);
  localparam int HIST_W = MAX_POS * SYM_W;

  logic                             push;
  logic [HIST_W-1:0]                hist_nxt;
  logic [CNT_W-1:0]                 fill_nxt;
  logic [CNT_W-1:0]                 nlen;
  logic                             armed;
  logic [NSEQ-1:0][HIST_W-1:0]      pats;
  logic [NSEQ-1:0][MAX_POS-1:0]     ens;
  logic [NSEQ-1:0]                  m;

  assign in_ready = 1'b1;
  assign push     = in_valid;
  assign nlen     = len_decode(seq_len);
  assign armed    = (fill_nxt >= nlen);

  assign pats[0] = seq1_sym;
  assign pats[1] = seq2_sym;
  assign ens[0]  = seq1_en;
  assign ens[1]  = seq2_en;

  ccm_history #(.DEPTH(MAX_POS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .din      ({in_disp, in_ctrl, in_data}),
    .hist_nxt (hist_nxt),
    .fill_nxt (fill_nxt)
  );

  for (genvar s = 0; s < NSEQ; s++) begin : g_seq
    ccm_seq_cmp #(.DEPTH(MAX_POS)) u_cmp (
      .hist  (hist_nxt),
      .pat   (pats[s]),
      .en    (ens[s]),
      .nlen  (nlen),
      .match (m[s])
    );
  end

  ccm_hit_merge u_merge (
    .clk     (clk),
    .rst     (rst),
    .fire    (push & armed),
    .m1      (m[0]),
    .m2      (m[1]),
    .hit1    (hit1),
    .hit2    (hit2),
    .hit_any (hit_any),
    .hit_sel (hit_sel)
  );
endmodule

// File: rtl/ccm_checker.sv
module ccm_checker
  import ccm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [1:0]         seq_len,
  input logic [MAX_POS-1:0] seq1_en,
  input logic               hit1,
  input logic               hit2,
  input logic               hit_any,
  input logic               hit_sel
);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_valid && seen < CNT_W'(MAX_POS)) seen <= seen + CNT_W'(1);
  end

  // R5: hits only follow an accepted symbol
  p_hit_after_push_r5: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> $past(in_valid));

  // R6: priority to sequence 1
  p_sel_priority_r6: assert property (@(posedge clk) disable iff (rst)
    hit_sel |-> (hit2 && !hit1));

  // R6: combined flag covers both individual hits
  p_any_covers_r6: assert property (@(posedge clk) disable iff (rst)
    (hit1 || hit2) |-> hit_any);

  // R7: no hit before enough symbols
  p_fill_r7: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (seen >= len_decode($past(seq_len))));

  // R4: fully masked sequence matches once filled
  p_mask_all_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && ($past(seq1_en) == '0) &&
     (seen >= len_decode($past(seq_len)))) |-> hit1);
endmodule

bind ccm_matcher ccm_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .seq_len  (seq_len),
  .seq1_en  (seq1_en),
  .hit1     (hit1),
  .hit2     (hit2),
  .hit_any  (hit_any),
  .hit_sel  (hit_sel)
);

// File: tb/tb_ccm_matcher.sv
module tb_ccm_matcher;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_ctrl;
  logic        in_disp;
  logic [1:0]  seq_len;
  logic [39:0] seq1_sym, seq2_sym;
  logic [3:0]  seq1_en, seq2_en;
  logic        hit1, hit2, hit_any, hit_sel;

  int checks = 0;
  int fails  = 0;
  logic [9:0] hb [4];
  int hcnt;
  bit e1, e2;

  always #5 clk = ~clk;

  ccm_matcher dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_disp(in_disp),
    .seq_len(seq_len), .seq1_sym(seq1_sym), .seq1_en(seq1_en),
    .seq2_sym(seq2_sym), .seq2_en(seq2_en),
    .hit1(hit1), .hit2(hit2), .hit_any(hit_any), .hit_sel(hit_sel)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [39:0] pat, input logic [3:0] en, input logic [1:0] lc);
    int n;
    n = (lc == 2'b00) ? 1 : (lc == 2'b01) ? 2 : 4;
    if (hcnt < n) return 1'b0;
    for (int k = 0; k < n; k++)
      if (en[k] && hb[n-1-k] != pat[10*k +: 10]) return 1'b0;
    return 1'b1;
  endfunction

  // drive at negedge, accept at posedge, check at the following negedge
  task automatic step(input string tag, input bit v, input logic [9:0] s);
    in_valid = v;
    {in_disp, in_ctrl, in_data} = s;
    @(posedge clk);
    if (v) begin
      for (int i = 3; i > 0; i--) hb[i] = hb[i-1];
      hb[0] = s;
      if (hcnt < 4) hcnt++;
    end
    e1 = v && exp_hit(seq1_sym, seq1_en, seq_len);
    e2 = v && exp_hit(seq2_sym, seq2_en, seq_len);
    @(negedge clk);
    chk(tag, "hit1", hit1, e1);
    chk(tag, "hit2", hit2, e2);
    chk(tag, "hit_any", hit_any, e1 | e2);
    chk(tag, "hit_sel", hit_sel, e2 & ~e1);
    chk("R8", "in_ready", in_ready, 1'b1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hcnt = 0;
    for (int i = 0; i < 4; i++) hb[i] = '0;
  endtask

  localparam logic [9:0] SA = 10'h1BC, SB = 10'h0B5, SC = 10'h2B5, SD = 10'h01C;

  initial begin
    in_data = '0; in_ctrl = 0; in_disp = 0;
    seq_len = 2'b01;
    seq1_sym = '0; seq1_en = 4'b0000;
    seq2_sym = {4{10'h3FF}}; seq2_en = 4'b1111;
    @(negedge clk);
    do_reset();
    chk("R7", "reset hit_any", hit_any, 1'b0);
    chk("R7", "reset hit1", hit1, 1'b0);
    chk("R8", "reset in_ready", in_ready, 1'b1);

    // fill rule: masked sequence of length 2 needs two symbols
    step("R7_fill", 1, SB);
    chk("R7", "first symbol no hit", hit1, 1'b0);
    step("R7_fill", 1, SB);
    chk("R7", "second symbol hit", hit1, 1'b1);

    // length 1 matching
    seq_len = 2'b00; seq1_sym = {30'd0, SA}; seq1_en = 4'b0001;
    step("R3_len1", 1, SB);
    step("R3_len1", 1, SA);
    chk("R3", "len1 hit", hit1, 1'b1);
    step("R3_len1", 0, SA);
    chk("R5", "idle no hit", hit1, 1'b0);

    // order: four symbols, position 1 earliest
    seq_len = 2'b10; seq1_sym = {SD, SC, SB, SA}; seq1_en = 4'b1111;
    step("R2_order", 1, SD); step("R2_order", 1, SC);
    step("R2_order", 1, SB); step("R2_order", 1, SA);
    chk("R2", "reverse no hit", hit1, 1'b0);
    step("R2_order", 1, SB); step("R2_order", 1, SC);
    step("R2_order", 1, SD);
    chk("R2", "forward hit", hit1, 1'b1);

    // idle gaps do not shift
    seq_len = 2'b11;
    step("R5_gap", 1, SA); step("R5_gap", 0, SD);
    step("R5_gap", 1, SB); step("R5_gap", 0, SA);
    step("R5_gap", 0, SA); step("R5_gap", 1, SC);
    step("R5_gap", 1, SD);
    chk("R5", "gapped hit", hit1, 1'b1);
    step("R5_gap", 0, SD);
    chk("R5", "single pulse", hit1, 1'b0);

    // flags take part in the comparison
    seq_len = 2'b00; seq1_sym = {30'd0, SA}; seq1_en = 4'b0001;
    step("R1_ctrl", 1, SA ^ 10'h100);
    chk("R1", "ctrl flag differs", hit1, 1'b0);
    step("R1_disp", 1, SA ^ 10'h200);
    chk("R1", "disp flag differs", hit1, 1'b0);
    step("R1_data", 1, SA ^ 10'h001);
    chk("R1", "data differs", hit1, 1'b0);

    // masking inside a length-4 window
    seq_len = 2'b10; seq1_sym = {SD, 10'h3FF, SB, 10'h3FF}; seq1_en = 4'b1010;
    step("R4_mask", 1, SC); step("R4_mask", 1, SB);
    step("R4_mask", 1, SA); step("R4_mask", 1, SD);
    chk("R4", "masked hit", hit1, 1'b1);

    // both sequences complete together; then sequence 2 alone
    seq_len = 2'b01; seq1_sym = {20'd0, SB, SA}; seq1_en = 4'b0011;
    seq2_sym = {20'd0, SB, 10'h000}; seq2_en = 4'b0010;
    step("R6_both", 1, SA); step("R6_both", 1, SB);
    chk("R6", "both sel seq1", hit_sel, 1'b0);
    chk("R6", "both any", hit_any, 1'b1);
    step("R6_alone", 1, SC); step("R6_alone", 1, SB);
    chk("R6", "seq2 alone sel", hit_sel, 1'b1);

    // reset mid-stream clears history
    seq_len = 2'b10; seq1_sym = {SA, SA, SA, SA}; seq1_en = 4'b1111;
    step("R7_rst", 1, SA); step("R7_rst", 1, SA); step("R7_rst", 1, SA);
    do_reset();
    step("R7_rst", 1, SA);
    chk("R7", "history cleared", hit1, 1'b0);

    // random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] alpha [4];
      alpha[0] = SA; alpha[1] = SB; alpha[2] = SC; alpha[3] = SD;
      if (i % 200 == 0) begin
        seq_len = 2'($urandom);
        for (int k = 0; k < 4; k++) begin
          seq1_sym[10*k +: 10] = alpha[$urandom % 4];
          seq2_sym[10*k +: 10] = alpha[$urandom % 4];
        end
        seq1_en = 4'($urandom); seq2_en = 4'($urandom);
      end
      step("R3_R4_rand", ($urandom % 4) != 0, alpha[$urandom % 4]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule